// File: doc/BRIEF.md
# DMA Event and Interrupt Signalling Controller

This block holds the small set of shared signalling resources that the channel threads of a multi-channel DMA engine and the host CPU use to coordinate. There are eight general resources, indexed 0 to 7, and one abort resource at index 8. A mode bit per general resource, written at run time, decides how the resource behaves. In event mode it is a flag that is broadcast to every channel thread and consumed by a wait instruction. In interrupt mode it is a sticky line to the host that stays high until the host clears it.

A send strobe carries a resource index. It can come from a channel thread or from the host slave port. Each channel thread has its own wait strobe and index. A channel that waits on an inactive event is parked until the event is sent, and then it receives a one-cycle wake pulse. The abort resource is raised by a fault input, never by a send, and it always behaves as an interrupt. The host reads back raw status (event active or line high) and masked status (line high on a resource currently in interrupt mode).

Top module: `evirq_ctrl`

## Requirements
- R1: After reset every irq line, raw status bit, masked status bit, wake pulse and reject flag is 0, and every general resource is in event mode (mode bit 0).
- R2: With mode bit n at 0, a send on index n sets raw status bit n one cycle later. irq[n] and masked status bit n stay 0.
- R3: A wait strobe from channel c on an active event n gives wake[c] high for exactly one cycle on the next cycle, and raw status bit n drops in that same cycle.
- R4: A single send on event n releases every channel parked on n together. Their wake bits rise two cycles after the send, and raw bit n, which is high in between, then returns to 0.
- R5: A wait strobe on an inactive event parks the channel. No wake pulse appears for as long as the event is not sent.
- R6: A send and a wait strobe on the same event in the same cycle resolve to set. Raw bit n is 1 on the next cycle, and on the cycle after that the channel is woken and bit n is 0.
- R7: With mode bit n at 1, a send on n drives irq[n], raw bit n and masked bit n high one cycle later. They stay high across idle cycles.
- R8: A clear on index n lowers irq[n] one cycle later when n is in interrupt mode. A clear on an event-mode resource leaves an active event untouched.
- R9: If resource n is switched from interrupt mode to event mode while irq[n] is high, irq[n] and raw bit n stay high and masked bit n reads 0. A clear on n is then ignored. After switching back to interrupt mode, a clear lowers irq[n].
- R10: A send whose index is 8 or higher changes no resource state and raises sev_reject for one cycle on the next cycle.
- R11: fault_in raises irq[8] and masked bit 8 on the next cycle, whatever the mode bits hold. A clear on index 8 lowers it.
- R12: A send and a clear on the same interrupt-mode resource in the same cycle leave irq[n] high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Write strobe for the mode mask |
| mode_wdata | input | NUM_RES | Mode mask, bit n = 1 puts resource n in interrupt mode |
| sev_valid | input | 1 | Send strobe |
| sev_idx | input | clog2(NUM_RES+1) | Resource index of the send |
| wfe_valid | input | NUM_CH | Per-channel wait strobe |
| wfe_idx | input | NUM_CH x clog2(NUM_RES) | Per-channel wait resource index |
| clr_valid | input | 1 | Interrupt clear strobe |
| clr_idx | input | clog2(NUM_RES+1) | Resource index of the clear |
| fault_in | input | 1 | Fault indication that raises the abort interrupt |
| wake | output | NUM_CH | Per-channel one-cycle release pulse |
| irq | output | NUM_RES+1 | Interrupt lines, bit NUM_RES is abort |
| raw_status | output | NUM_RES+1 | Event active or line high, per resource |
| irq_status | output | NUM_RES+1 | Line high on a resource in interrupt mode |
| sev_reject | output | 1 | One-cycle flag for a send with an out-of-range index |

## Verification
The properties assume that strobes are sampled only at clock edges, and that an index arriving without its strobe is meaningless. On that basis they claim that a line can only rise in the cycle after a matching send or fault, and only fall in the cycle after a matching clear. The bench holds each strobe for exactly one cycle and drives it at the falling edge. It never issues a wait on an index outside the general range, which the port width also rules out. It does deliberately send to index 8 and beyond, to exercise rejection.

// File: rtl/evirq_pkg.sv
package evirq_pkg;

    // Mode bit value per resource
    typedef enum logic {
        MODE_EVENT = 1'b0,
        MODE_IRQ   = 1'b1
    } res_mode_e;

    // Per-channel wait state
    typedef enum logic {
        CH_IDLE    = 1'b0,
        CH_WAITING = 1'b1
    } ch_state_e;

endpackage

// File: rtl/evirq_mode_reg.sv
module evirq_mode_reg #(
    parameter int NUM_RES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [NUM_RES-1:0] wr_data,
    output logic [NUM_RES:0]   mode_eff
);
    import evirq_pkg::*;

    typedef struct packed {
        logic [NUM_RES-1:0] mode;
    } mode_st_t;

    mode_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.mode = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // The abort resource has no writable bit: it is always an interrupt
    assign mode_eff = {MODE_IRQ, st_q.mode};

endmodule

// File: rtl/evirq_wait_unit.sv
module evirq_wait_unit #(
    parameter int NUM_RES = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wfe_valid,
    input  logic [$clog2(NUM_RES)-1:0] wfe_idx,
    input  logic [NUM_RES-1:0]         ev_active,
    output logic                       wake,
    output logic [NUM_RES-1:0]         consume
);
    import evirq_pkg::*;

    localparam int EIW = $clog2(NUM_RES);

    typedef struct packed {
        ch_state_e      st;
        logic [EIW-1:0] idx;
        logic           wake;
    } wait_st_t;

    wait_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.wake = 1'b0;
        consume   = '0;
        if (wfe_valid) begin
            // A new wait replaces any wait already parked
            if (ev_active[wfe_idx]) begin
                consume[wfe_idx] = 1'b1;
                st_d.wake        = 1'b1;
                st_d.st          = CH_IDLE;
            end else begin
                st_d.st  = CH_WAITING;
                st_d.idx = wfe_idx;
            end
        end else if (st_q.st == CH_WAITING && ev_active[st_q.idx]) begin
            consume[st_q.idx] = 1'b1;
            st_d.wake         = 1'b1;
            st_d.st           = CH_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{st: CH_IDLE, idx: '0, wake: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign wake = st_q.wake;

endmodule

// File: rtl/evirq_res_bank.sv
module evirq_res_bank #(
    parameter int NUM_RES = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sev_valid,
    input  logic [$clog2(NUM_RES+1)-1:0] sev_idx,
    input  logic                         clr_valid,
    input  logic [$clog2(NUM_RES+1)-1:0] clr_idx,
    input  logic                         fault_in,
    input  logic [NUM_RES:0]             mode_eff,
    input  logic [NUM_RES-1:0]           consume,
    output logic [NUM_RES-1:0]           ev_active,
    output logic [NUM_RES:0]             irq,
    output logic                         sev_reject
);
    import evirq_pkg::*;

    localparam int IW    = $clog2(NUM_RES + 1);
    localparam int TOT   = NUM_RES + 1;
    localparam int ABORT = NUM_RES;

    typedef struct packed {
        logic [NUM_RES-1:0] ev;
        logic [TOT-1:0]     irq;
        logic               rej;
    } bank_st_t;

    bank_st_t st_d, st_q;

    logic [NUM_RES-1:0] sev_hit;
    logic [TOT-1:0]     clr_hit;

    // Index decode for send (general range only) and clear (full range)
    always_comb begin
        for (int n = 0; n < NUM_RES; n++) begin
            sev_hit[n] = sev_valid && (sev_idx == IW'(n));
        end
        for (int n = 0; n < TOT; n++) begin
            clr_hit[n] = clr_valid && (clr_idx == IW'(n));
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.rej = sev_valid && (int'(sev_idx) >= NUM_RES);
        for (int n = 0; n < NUM_RES; n++) begin
            // Event flag: a send wins over a consumption in the same cycle
            if (sev_hit[n] && mode_eff[n] == MODE_EVENT) begin
                st_d.ev[n] = 1'b1;
            end else if (consume[n]) begin
                st_d.ev[n] = 1'b0;
            end
            // Interrupt line: a send wins over a clear; clear needs irq mode
            if (sev_hit[n] && mode_eff[n] == MODE_IRQ) begin
                st_d.irq[n] = 1'b1;
            end else if (clr_hit[n] && mode_eff[n] == MODE_IRQ) begin
                st_d.irq[n] = 1'b0;
            end
        end
        if (fault_in) begin
            st_d.irq[ABORT] = 1'b1;
        end else if (clr_hit[ABORT] && mode_eff[ABORT] == MODE_IRQ) begin
            st_d.irq[ABORT] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ev_active  = st_q.ev;
    assign irq        = st_q.irq;
    assign sev_reject = st_q.rej;

endmodule

// File: rtl/evirq_ctrl.sv
module evirq_ctrl #(
    parameter int NUM_RES = 8,
    parameter int NUM_CH  = 4
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      mode_wr,
    input  logic [NUM_RES-1:0]                        mode_wdata,
    input  logic                                      sev_valid,
    input  logic [$clog2(NUM_RES+1)-1:0]              sev_idx,
    input  logic [NUM_CH-1:0]                         wfe_valid,
    input  logic [NUM_CH-1:0][$clog2(NUM_RES)-1:0]    wfe_idx,
    input  logic                                      clr_valid,
    input  logic [$clog2(NUM_RES+1)-1:0]              clr_idx,
    input  logic                                      fault_in,
    output logic [NUM_CH-1:0]                         wake,
    output logic [NUM_RES:0]                          irq,
    output logic [NUM_RES:0]                          raw_status,
    output logic [NUM_RES:0]                          irq_status,
    output logic                                      sev_reject
);
    localparam int TOT = NUM_RES + 1;

    logic [TOT-1:0]                  mode_eff;
    logic [NUM_RES-1:0]              ev_active;
    logic [NUM_CH-1:0][NUM_RES-1:0]  consume_ch;
    logic [NUM_RES-1:0]              consume_any;

    evirq_mode_reg #(.NUM_RES(NUM_RES)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (mode_wr),
        .wr_data  (mode_wdata),
        .mode_eff (mode_eff)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        evirq_wait_unit #(.NUM_RES(NUM_RES)) u_wait (
            .clk       (clk),
            .rst_n     (rst_n),
            .wfe_valid (wfe_valid[c]),
            .wfe_idx   (wfe_idx[c]),
            .ev_active (ev_active),
            .wake      (wake[c]),
            .consume   (consume_ch[c])
        );
    end

    // Broadcast: any channel that consumes an event clears it for all
    always_comb begin
        consume_any = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            consume_any = consume_any | consume_ch[c];
        end
    end

    evirq_res_bank #(.NUM_RES(NUM_RES)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .sev_valid  (sev_valid),
        .sev_idx    (sev_idx),
        .clr_valid  (clr_valid),
        .clr_idx    (clr_idx),
        .fault_in   (fault_in),
        .mode_eff   (mode_eff),
        .consume    (consume_any),
        .ev_active  (ev_active),
        .irq        (irq),
        .sev_reject (sev_reject)
    );

    assign raw_status = {irq[NUM_RES], ev_active | irq[NUM_RES-1:0]};
    assign irq_status = irq & mode_eff;

endmodule

// File: rtl/evirq_ctrl_chk.sv
module evirq_ctrl_chk #(
    parameter int NUM_RES = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         sev_valid,
    input logic [$clog2(NUM_RES+1)-1:0] sev_idx,
    input logic                         clr_valid,
    input logic [$clog2(NUM_RES+1)-1:0] clr_idx,
    input logic                         fault_in,
    input logic [NUM_RES:0]             irq,
    input logic [NUM_RES:0]             mode_eff,
    input logic                         sev_reject
);
    localparam int IW    = $clog2(NUM_RES + 1);
    localparam int TOT   = NUM_RES + 1;
    localparam int ABORT = NUM_RES;

    // R10: out-of-range send is flagged on the next cycle
    p_reject_out_of_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sev_valid && int'(sev_idx) >= NUM_RES) |=> sev_reject);

    // R11: abort line rises only after a fault
    p_abort_rise_needs_fault_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq[ABORT]) |-> $past(fault_in));

    for (genvar n = 0; n < TOT; n++) begin : g_all
        // R8: a line falls only after a clear naming it
        p_fall_needs_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq[n]) |-> $past(clr_valid && clr_idx == IW'(n)));
    end

    for (genvar n = 0; n < NUM_RES; n++) begin : g_gen
        // R7: a general line rises only after a send naming it
        p_rise_needs_send_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[n]) |-> $past(sev_valid && sev_idx == IW'(n)));
        // R9: a clear on an event-mode resource leaves a high line high
        p_clear_ignored_in_event_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[n] && clr_valid && clr_idx == IW'(n) && !mode_eff[n]) |=> irq[n]);
    end

endmodule

bind evirq_ctrl evirq_ctrl_chk #(.NUM_RES(NUM_RES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sev_valid  (sev_valid),
    .sev_idx    (sev_idx),
    .clr_valid  (clr_valid),
    .clr_idx    (clr_idx),
    .fault_in   (fault_in),
    .irq        (irq),
    .mode_eff   (mode_eff),
    .sev_reject (sev_reject)
);

// File: tb/evirq_ctrl_tb.sv
`timescale 1ns/1ps
module evirq_ctrl_tb;
    localparam int NUM_RES = 8;
    localparam int NUM_CH  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_wr = 1'b0;
    logic [7:0]       mode_wdata = '0;
    logic             sev_valid = 1'b0;
    logic [3:0]       sev_idx = '0;
    logic [3:0]       wfe_valid = '0;
    logic [3:0][2:0]  wfe_idx = '0;
    logic             clr_valid = 1'b0;
    logic [3:0]       clr_idx = '0;
    logic             fault_in = 1'b0;
    logic [3:0]       wake;
    logic [8:0]       irq;
    logic [8:0]       raw_status;
    logic [8:0]       irq_status;
    logic             sev_reject;

    int nvec = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    evirq_ctrl #(.NUM_RES(NUM_RES), .NUM_CH(NUM_CH)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .sev_valid(sev_valid), .sev_idx(sev_idx), .wfe_valid(wfe_valid),
        .wfe_idx(wfe_idx), .clr_valid(clr_valid), .clr_idx(clr_idx),
        .fault_in(fault_in), .wake(wake), .irq(irq), .raw_status(raw_status),
        .irq_status(irq_status), .sev_reject(sev_reject)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Advance to the next falling edge and drop every strobe
    task automatic tick();
        @(negedge clk);
        mode_wr   = 1'b0;
        sev_valid = 1'b0;
        wfe_valid = '0;
        clr_valid = 1'b0;
        fault_in  = 1'b0;
    endtask

    task automatic set_mode(input logic [7:0] m);
        mode_wr = 1'b1; mode_wdata = m; tick();
    endtask

    task automatic send(input logic [3:0] n);
        sev_valid = 1'b1; sev_idx = n; tick();
    endtask

    task automatic clear(input logic [3:0] n);
        clr_valid = 1'b1; clr_idx = n; tick();
    endtask

    task automatic t_reset();
        chk("R1", "irq", irq, 0);
        chk("R1", "raw", raw_status, 0);
        chk("R1", "masked", irq_status, 0);
        chk("R1", "wake", wake, 0);
        chk("R1", "reject", sev_reject, 0);
    endtask

    task automatic t_event_send();
        send(4'd2);
        chk("R2", "raw", raw_status, 9'h004);
        chk("R2", "irq", irq, 0);
        chk("R2", "masked", irq_status, 0);
    endtask

    task automatic t_wfe_consume();
        wfe_valid[1] = 1'b1; wfe_idx[1] = 3'd2; tick();
        chk("R3", "wake", wake, 4'b0010);
        chk("R3", "raw", raw_status, 0);
        tick();
        chk("R3", "wake one cycle", wake, 0);
    endtask

    task automatic t_park_and_broadcast();
        wfe_valid = 4'b1101;
        wfe_idx[0] = 3'd6; wfe_idx[2] = 3'd6; wfe_idx[3] = 3'd6;
        tick();
        chk("R5", "no wake", wake, 0);
        tick(); tick(); tick();
        chk("R5", "still parked", wake, 0);
        send(4'd6);
        chk("R4", "raw mid", raw_status, 9'h040);
        chk("R4", "wake mid", wake, 0);
        tick();
        chk("R4", "all woken", wake, 4'b1101);
        chk("R4", "raw after", raw_status, 0);
        tick();
        chk("R4", "wake drops", wake, 0);
    endtask

    task automatic t_same_cycle();
        sev_valid = 1'b1; sev_idx = 4'd5;
        wfe_valid[1] = 1'b1; wfe_idx[1] = 3'd5;
        tick();
        chk("R6", "raw set", raw_status, 9'h020);
        chk("R6", "wake early", wake, 0);
        tick();
        chk("R6", "wake", wake, 4'b0010);
        chk("R6", "raw cleared", raw_status, 0);
        tick();
    endtask

    task automatic t_irq_mode();
        set_mode(8'h10);
        send(4'd4);
        chk("R7", "irq", irq, 9'h010);
        chk("R7", "raw", raw_status, 9'h010);
        chk("R7", "masked", irq_status, 9'h010);
        tick(); tick(); tick();
        chk("R7", "sticky", irq, 9'h010);
    endtask

    task automatic t_clear();
        clear(4'd4);
        chk("R8", "cleared", irq, 0);
        send(4'd2);
        clear(4'd2);
        chk("R8", "event untouched", raw_status, 9'h004);
        wfe_valid[0] = 1'b1; wfe_idx[0] = 3'd2; tick();
        chk("R8", "event still consumable", wake, 4'b0001);
        tick();
    endtask

    task automatic t_mode_switch();
        send(4'd4);
        set_mode(8'h00);
        chk("R9", "irq held", irq, 9'h010);
        chk("R9", "raw held", raw_status, 9'h010);
        chk("R9", "masked off", irq_status, 0);
        clear(4'd4);
        chk("R9", "clear ignored", irq, 9'h010);
        set_mode(8'h10);
        clear(4'd4);
        chk("R9", "clear after switch back", irq, 0);
        set_mode(8'h00);
    endtask

    task automatic t_reject();
        send(4'd8);
        chk("R10", "reject", sev_reject, 1);
        chk("R10", "irq", irq, 0);
        chk("R10", "raw", raw_status, 0);
        tick();
        chk("R10", "reject one cycle", sev_reject, 0);
        send(4'd12);
        chk("R10", "reject high idx", sev_reject, 1);
        chk("R10", "raw high idx", raw_status, 0);
        tick();
    endtask

    task automatic t_abort();
        set_mode(8'h00);
        fault_in = 1'b1; tick();
        chk("R11", "irq", irq, 9'h100);
        chk("R11", "masked", irq_status, 9'h100);
        clear(4'd8);
        chk("R11", "cleared", irq, 0);
    endtask

    task automatic t_set_wins();
        set_mode(8'h80);
        sev_valid = 1'b1; sev_idx = 4'd7;
        clr_valid = 1'b1; clr_idx = 4'd7;
        tick();
        chk("R12", "set wins", irq, 9'h080);
        clear(4'd7);
        chk("R12", "later clear", irq, 0);
        set_mode(8'h00);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_event_send();
        t_wfe_consume();
        t_park_and_broadcast();
        t_same_cycle();
        t_irq_mode();
        t_clear();
        t_mode_switch();
        t_reject();
        t_abort();
        t_set_wins();
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        nvec++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule